// File: doc/BRIEF.md
# Event Interrupt Controller with Circular Log

This block is the interrupt section of a MIL-STD-1553 bus controller / remote terminal. The protocol engine hands it one-cycle strobes, one per event source, together with the two pointers that belong to the message being handled. Two CPU-programmed enable masks gate the strobes. Events that pass the standard mask drive a sticky level interrupt and a counted pulse interrupt. Events that pass the high-priority mask set per-event status bits, and those bits drive a high-priority interrupt. The CPU clears a status bit by writing a 1 to it.

Every cycle that carries at least one enabled event produces one log record. The record is three 16-bit words: a status word, the command block pointer and the descriptor pointer. The block writes these words over a plain memory write port into a circular list, starting at a tail pointer that wraps inside a CPU-defined window. Records wait in a two-deep pending buffer while an earlier record is still being written.

Top module: `irq_log_ctrl`

## Requirements
- R1: After synchronous reset every interrupt output and mem_we are low. Both enable masks, the status register and the list base read 0, the list length reads 12, and the tail reads 0.
- R2: irq_std_level rises in the cycle after an edge that samples an event enabled in the standard mask (address 0). It stays high until a write to address 2 with bit 15 set. An enabled event in the same cycle as that write wins, and the level stays high.
- R3: irq_std_pulse is high for exactly one cycle per standard-enabled event occurrence. Occurrences are counted, so events in the same cycle give pulses on consecutive cycles. The first pulse is in the cycle after the sampling edge.
- R4: Each event enabled in the high-priority mask (address 1) sets its status bit at address 2, bits 9:0. Writing 1 to a bit clears it, and a new event in the same cycle wins. irq_hp is the OR of these bits.
- R5: An event that is enabled in neither mask changes no output, no status bit, and writes no log record.
- R6: A record is written on three consecutive mem_we cycles at tail, tail+1 and tail+2, in this order: status word, command block pointer, descriptor pointer. With an idle writer the first word appears in the second cycle after the sampling edge.
- R7: Status word: bit 15 is 1. Event i sets bit i for i = 0 to 7, event 8 sets bit 13 and event 9 sets bit 14. Bits 12:8 are 0. Only events enabled in either mask appear.
- R8: After each record the tail advances by 3. It returns to the list base when (tail+3 - base) is greater than or equal to the list length (address 4, in words).
- R9: Writing the list base (address 3) also moves the tail (address 5, read-only) to the new base.
- R10: Up to two records wait while one is being written. A record that arrives when both slots are full is discarded.
- R11: Reads are combinational: cpu_rdata shows the register selected by cpu_addr. Address 2 returns the standard pending flag in bit 15 and the high-priority bits in 9:0. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_strobe | input | 10 | One-cycle event strobes from the protocol engine |
| evt_cmd_ptr | input | 16 | Command block pointer for this cycle's events |
| evt_desc_ptr | input | 16 | Descriptor pointer for this cycle's events |
| cpu_wr | input | 1 | CPU register write strobe |
| cpu_addr | input | 3 | CPU register address |
| cpu_wdata | input | 16 | CPU write data |
| cpu_rdata | output | 16 | CPU read data |
| irq_std_level | output | 1 | Sticky standard interrupt |
| irq_std_pulse | output | 1 | One cycle per standard event |
| irq_hp | output | 1 | High-priority interrupt |
| mem_we | output | 1 | Log memory write enable |
| mem_addr | output | 16 | Log memory word address |
| mem_wdata | output | 16 | Log memory write data |

## Verification
The bench fires three standard events in one cycle; a design that ORs them instead of counting them would give a single pulse where three are due. It writes the clear bits in the same cycle as fresh events, which catches a design that lets the clear win and loses an interrupt. A four-cycle burst overruns the pending buffer: a design that writes over a slot in use would log a wrong record, and one without a buffer would log fewer than three records. The tail is run across the wrap point and is also moved by a base write, so an off-by-one in the wrap compare shows up as a record at the wrong address.

// File: rtl/irq_log_pkg.sv
package irq_log_pkg;

    localparam int unsigned NUM_EVT = 10;
    localparam int unsigned WORD_W  = 16;

    // CPU register addresses
    localparam logic [2:0] A_STD_EN  = 3'd0;
    localparam logic [2:0] A_HP_EN   = 3'd1;
    localparam logic [2:0] A_HP_STAT = 3'd2;
    localparam logic [2:0] A_BASE    = 3'd3;
    localparam logic [2:0] A_LEN     = 3'd4;
    localparam logic [2:0] A_TAIL    = 3'd5;

    localparam int unsigned STD_PEND_BIT = 15;

    typedef struct packed {
        logic [WORD_W-1:0] status;
        logic [WORD_W-1:0] cmd_ptr;
        logic [WORD_W-1:0] desc_ptr;
    } log_entry_t;

    typedef enum logic [1:0] {
        W_IDLE = 2'd0,
        W_STAT = 2'd1,
        W_CMD  = 2'd2,
        W_DESC = 2'd3
    } wr_state_e;

    // place event flags at their status-word positions
    function automatic logic [WORD_W-1:0] pack_status(input logic [NUM_EVT-1:0] ev);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[15]    = 1'b1;
        w[7:0]   = ev[7:0];
        w[13]    = ev[8];
        w[14]    = ev[9];
        return w;
    endfunction

    function automatic logic [3:0] count_set(input logic [NUM_EVT-1:0] v);
        logic [3:0] n;
        n = '0;
        for (int i = 0; i < NUM_EVT; i++) n = n + {3'b0, v[i]};
        return n;
    endfunction

endpackage

// File: rtl/irq_gate.sv
module irq_gate
    import irq_log_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt,
    input  logic [NUM_EVT-1:0] std_en,
    input  logic [NUM_EVT-1:0] hp_en,
    input  logic               clr_std,
    input  logic [NUM_EVT-1:0] hp_clr,
    output logic               std_level,
    output logic               std_pulse,
    output logic [NUM_EVT-1:0] hp_stat,
    output logic               irq_hp,
    output logic [NUM_EVT-1:0] log_hit
);
    localparam logic [CNT_W:0] CNT_MAX = {1'b0, {CNT_W{1'b1}}};

    logic [NUM_EVT-1:0] std_hit, hp_hit;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W:0]     cnt_sum;

    assign std_hit = evt & std_en;
    assign hp_hit  = evt & hp_en;
    assign log_hit = evt & (std_en | hp_en);

    always_comb begin
        cnt_sum = {1'b0, cnt_q} + (CNT_W+1)'(count_set(std_hit));
        if (cnt_q != '0) cnt_sum = cnt_sum - 1'b1;
        if (cnt_sum > CNT_MAX) cnt_sum = CNT_MAX;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            std_level <= 1'b0;
            hp_stat   <= '0;
            cnt_q     <= '0;
        end else begin
            if (|std_hit)     std_level <= 1'b1;
            else if (clr_std) std_level <= 1'b0;
            hp_stat <= (hp_stat & ~hp_clr) | hp_hit;
            cnt_q   <= cnt_sum[CNT_W-1:0];
        end
    end

    assign std_pulse = (cnt_q != '0);
    assign irq_hp    = |hp_stat;

    a_r2_level_set: assert property (@(posedge clk) disable iff (rst)
        (|(evt & std_en)) |=> std_level);
    a_r2_level_hold: assert property (@(posedge clk) disable iff (rst)
        (std_level && !clr_std) |=> std_level);
    a_r3_pulse_follows: assert property (@(posedge clk) disable iff (rst)
        (|(evt & std_en)) |=> std_pulse);
    a_r4_hp_raise: assert property (@(posedge clk) disable iff (rst)
        (|(evt & hp_en)) |=> irq_hp);

endmodule

// File: rtl/irq_log_fifo.sv
module irq_log_fifo
    import irq_log_pkg::*;
#(
    parameter int unsigned DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       push,
    input  log_entry_t push_data,
    input  logic       pop,
    output logic       nonempty,
    output log_entry_t head
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    log_entry_t    slot [DEPTH];
    logic [PW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign do_push  = push && (cnt != FULL);
    assign do_pop   = pop && (cnt != '0);
    assign nonempty = (cnt != '0);
    assign head     = slot[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) begin
                slot[wp] <= push_data;
                wp <= (wp == LAST) ? '0 : wp + 1'b1;
            end
            if (do_pop) rp <= (rp == LAST) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    a_r10_keep_on_full: assert property (@(posedge clk) disable iff (rst)
        (cnt == FULL && !pop) |=> (cnt == FULL));

endmodule

// File: rtl/irq_log_writer.sv
module irq_log_writer
    import irq_log_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_nonempty,
    input  log_entry_t        fifo_head,
    output logic              fifo_pop,
    input  logic [WORD_W-1:0] base,
    input  logic [WORD_W-1:0] len,
    input  logic              base_wr,
    input  logic [WORD_W-1:0] base_val,
    output logic [WORD_W-1:0] tail,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata
);
    wr_state_e         state;
    log_entry_t        cur;
    logic [WORD_W-1:0] adv, span, tail_nxt;
    logic [1:0]        word_off;

    assign fifo_pop = fifo_nonempty && (state == W_IDLE || state == W_DESC);

    always_comb begin
        adv      = tail + WORD_W'(3);
        span     = adv - base;
        tail_nxt = (span >= len) ? base : adv;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= W_IDLE;
            cur   <= '0;
            tail  <= '0;
        end else begin
            if (fifo_pop) cur <= fifo_head;
            unique case (state)
                W_IDLE:  state <= fifo_pop ? W_STAT : W_IDLE;
                W_STAT:  state <= W_CMD;
                W_CMD:   state <= W_DESC;
                W_DESC:  state <= fifo_pop ? W_STAT : W_IDLE;
                default: state <= W_IDLE;
            endcase
            if (base_wr)              tail <= base_val;
            else if (state == W_DESC) tail <= tail_nxt;
        end
    end

    always_comb begin
        mem_we   = (state != W_IDLE);
        word_off = 2'(state) - 2'd1;
        mem_addr = tail + {{(WORD_W-2){1'b0}}, word_off};
        unique case (state)
            W_STAT:  mem_wdata = cur.status;
            W_CMD:   mem_wdata = cur.cmd_ptr;
            W_DESC:  mem_wdata = cur.desc_ptr;
            default: mem_wdata = '0;
        endcase
    end

    a_r6_addr_step: assert property (@(posedge clk) disable iff (rst)
        (mem_we && state != W_DESC) |=> (mem_we && mem_addr == $past(mem_addr) + 16'd1));
    a_r6_order: assert property (@(posedge clk) disable iff (rst)
        (state == W_STAT) |=> (state == W_CMD));

endmodule

// File: rtl/irq_log_ctrl.sv
module irq_log_ctrl
    import irq_log_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 2,
    parameter int unsigned CNT_W      = 8,
    parameter logic [15:0] LEN_RST    = 16'd12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt_strobe,
    input  logic [15:0]        evt_cmd_ptr,
    input  logic [15:0]        evt_desc_ptr,
    input  logic               cpu_wr,
    input  logic [2:0]         cpu_addr,
    input  logic [15:0]        cpu_wdata,
    output logic [15:0]        cpu_rdata,
    output logic               irq_std_level,
    output logic               irq_std_pulse,
    output logic               irq_hp,
    output logic               mem_we,
    output logic [15:0]        mem_addr,
    output logic [15:0]        mem_wdata
);
    logic [NUM_EVT-1:0] std_en, hp_en, hp_stat, hp_clr, log_hit;
    logic [15:0]        base, len, tail;
    logic               clr_std, base_wr, fifo_nonempty, fifo_pop;
    log_entry_t         new_entry, fifo_head;

    assign clr_std = cpu_wr && cpu_addr == A_HP_STAT && cpu_wdata[STD_PEND_BIT];
    assign hp_clr  = (cpu_wr && cpu_addr == A_HP_STAT) ? cpu_wdata[NUM_EVT-1:0] : '0;
    assign base_wr = cpu_wr && cpu_addr == A_BASE;

    always_ff @(posedge clk) begin
        if (rst) begin
            std_en <= '0;
            hp_en  <= '0;
            base   <= '0;
            len    <= LEN_RST;
        end else if (cpu_wr) begin
            case (cpu_addr)
                A_STD_EN: std_en <= cpu_wdata[NUM_EVT-1:0];
                A_HP_EN:  hp_en  <= cpu_wdata[NUM_EVT-1:0];
                A_BASE:   base   <= cpu_wdata;
                A_LEN:    len    <= cpu_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (cpu_addr)
            A_STD_EN:  cpu_rdata = {{(16-NUM_EVT){1'b0}}, std_en};
            A_HP_EN:   cpu_rdata = {{(16-NUM_EVT){1'b0}}, hp_en};
            A_HP_STAT: cpu_rdata = {irq_std_level, {(15-NUM_EVT){1'b0}}, hp_stat};
            A_BASE:    cpu_rdata = base;
            A_LEN:     cpu_rdata = len;
            A_TAIL:    cpu_rdata = tail;
            default:   cpu_rdata = '0;
        endcase
    end

    irq_gate #(.CNT_W(CNT_W)) u_gate (
        .clk(clk), .rst(rst), .evt(evt_strobe), .std_en(std_en), .hp_en(hp_en),
        .clr_std(clr_std), .hp_clr(hp_clr), .std_level(irq_std_level),
        .std_pulse(irq_std_pulse), .hp_stat(hp_stat), .irq_hp(irq_hp), .log_hit(log_hit)
    );

    assign new_entry = '{status: pack_status(log_hit), cmd_ptr: evt_cmd_ptr, desc_ptr: evt_desc_ptr};

    irq_log_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(|log_hit), .push_data(new_entry),
        .pop(fifo_pop), .nonempty(fifo_nonempty), .head(fifo_head)
    );

    irq_log_writer u_writer (
        .clk(clk), .rst(rst), .fifo_nonempty(fifo_nonempty), .fifo_head(fifo_head),
        .fifo_pop(fifo_pop), .base(base), .len(len), .base_wr(base_wr),
        .base_val(cpu_wdata), .tail(tail), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata)
    );

    a_r5_quiet_when_disabled: assert property (@(posedge clk) disable iff (rst)
        (!fifo_nonempty && !mem_we && !irq_std_pulse && !(|(evt_strobe & (std_en | hp_en))))
        |=> !mem_we);

endmodule

// File: tb/irq_log_ctrl_tb.sv
module irq_log_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  evt_strobe = '0;
    logic [15:0] evt_cmd_ptr = '0, evt_desc_ptr = '0;
    logic        cpu_wr = 1'b0;
    logic [2:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata, mem_addr, mem_wdata;
    logic        irq_std_level, irq_std_pulse, irq_hp, mem_we;

    int n_cmp = 0, n_bad = 0, we_seen = 0;
    bit started = 0;

    always #10 clk = ~clk;

    irq_log_ctrl u_dut (
        .clk(clk), .rst(rst), .evt_strobe(evt_strobe), .evt_cmd_ptr(evt_cmd_ptr),
        .evt_desc_ptr(evt_desc_ptr), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .irq_std_level(irq_std_level),
        .irq_std_pulse(irq_std_pulse), .irq_hp(irq_hp), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // behavioural reference model
    logic [9:0]  m_std_en, m_hp_en, m_hp;
    logic [15:0] m_base, m_len, m_tail;
    logic        m_pend;
    int          m_cnt, m_st;
    logic [15:0] q_s[$], q_c[$], q_d[$];
    logic [15:0] c_s, c_c, c_d;

    function automatic logic [15:0] status_of(input logic [9:0] ev);
        return 16'h8000 | {8'h00, ev[7:0]} | ({15'b0, ev[8]} << 13) | ({15'b0, ev[9]} << 14);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_std_en = '0; m_hp_en = '0; m_hp = '0; m_base = '0; m_len = 16'd12;
            m_tail = '0; m_pend = 0; m_cnt = 0; m_st = 0;
            q_s.delete(); q_c.delete(); q_d.delete();
            c_s = '0; c_c = '0; c_d = '0;
        end else begin
            logic [9:0] sh, hh, lh;
            int oldsz, pc;
            bool_blk: begin end
            sh = evt_strobe & m_std_en;
            hh = evt_strobe & m_hp_en;
            lh = evt_strobe & (m_std_en | m_hp_en);
            if (sh != 0) m_pend = 1;
            else if (cpu_wr && cpu_addr == 3'd2 && cpu_wdata[15]) m_pend = 0;
            m_hp = (m_hp & ~((cpu_wr && cpu_addr == 3'd2) ? cpu_wdata[9:0] : 10'h0)) | hh;
            pc = 0;
            for (int i = 0; i < 10; i++) if (sh[i]) pc++;
            m_cnt = m_cnt - ((m_cnt > 0) ? 1 : 0) + pc;
            if (m_cnt > 255) m_cnt = 255;
            oldsz = q_s.size();
            if (m_st == 3) begin
                m_tail = m_tail + 16'd3;
                if (16'(m_tail - m_base) >= m_len) m_tail = m_base;
            end
            if (m_st == 0 || m_st == 3) begin
                if (oldsz > 0) begin
                    c_s = q_s.pop_front(); c_c = q_c.pop_front(); c_d = q_d.pop_front();
                    m_st = 1;
                end else m_st = 0;
            end else m_st = m_st + 1;
            if (lh != 0 && oldsz < 2) begin
                q_s.push_back(status_of(lh)); q_c.push_back(evt_cmd_ptr); q_d.push_back(evt_desc_ptr);
            end
            if (cpu_wr) begin
                case (cpu_addr)
                    3'd0: m_std_en = cpu_wdata[9:0];
                    3'd1: m_hp_en = cpu_wdata[9:0];
                    3'd3: begin m_base = cpu_wdata; m_tail = cpu_wdata; end
                    3'd4: m_len = cpu_wdata;
                    default: ;
                endcase
            end
        end
        started = 1;
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare on every clock, away from the rising edge
    always @(negedge clk) begin
        if (started) begin
            logic [15:0] er;
            case (cpu_addr)
                3'd0: er = {6'b0, m_std_en};
                3'd1: er = {6'b0, m_hp_en};
                3'd2: er = {m_pend, 5'b0, m_hp};
                3'd3: er = m_base;
                3'd4: er = m_len;
                3'd5: er = m_tail;
                default: er = '0;
            endcase
            chk("R2 std level", {15'b0, irq_std_level}, {15'b0, m_pend});
            chk("R3 std pulse", {15'b0, irq_std_pulse}, {15'b0, (m_cnt > 0)});
            chk("R4 hp irq", {15'b0, irq_hp}, {15'b0, (m_hp != 0)});
            chk("R6 mem_we", {15'b0, mem_we}, {15'b0, (m_st != 0)});
            chk("R11 read data", cpu_rdata, er);
            if (m_st != 0) begin
                chk("R8 mem_addr", mem_addr, m_tail + 16'(m_st - 1));
                if (m_st == 1) chk("R7 status word", mem_wdata, c_s);
                else chk("R6 pointer word", mem_wdata, (m_st == 2) ? c_c : c_d);
            end
            if (mem_we) we_seen++;
        end
    end

    task automatic step(input logic [9:0] ev, input logic [15:0] cp, input logic [15:0] dp,
                        input logic wr, input logic [2:0] a, input logic [15:0] wd);
        @(posedge clk); #5;
        evt_strobe = ev; evt_cmd_ptr = cp; evt_desc_ptr = dp;
        cpu_wr = wr; cpu_addr = a; cpu_wdata = wd;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step('0, '0, '0, 0, 3'd0, '0);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [15:0] d);
        step('0, '0, '0, 1, a, d);
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [15:0] exp, input string tag);
        step('0, '0, '0, 0, a, '0);
        @(negedge clk); #1;
        chk(tag, cpu_rdata, exp);
    endtask

    task automatic fire(input logic [9:0] ev, input logic [15:0] cp, input logic [15:0] dp);
        step(ev, cp, dp, 0, 3'd0, '0);
    endtask

    initial begin
        int w0;
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int w0;
        repeat (3) @(posedge clk);
        #5 rst = 1'b0;
        // R1 reset values
        rd_chk(3'd0, 16'h0000, "R1 std enable");
        rd_chk(3'd1, 16'h0000, "R1 hp enable");
        rd_chk(3'd2, 16'h0000, "R1 status");
        rd_chk(3'd3, 16'h0000, "R1 base");
        rd_chk(3'd4, 16'd12,   "R1 length");
        rd_chk(3'd5, 16'h0000, "R1 tail");
        rd_chk(3'd7, 16'h0000, "R11 unused address");
        // R5 nothing enabled: no log, no outputs
        w0 = we_seen;
        fire(10'h3FF, 16'h1111, 16'h2222);
        fire(10'h155, 16'h1111, 16'h2222);
        idle(6);
        chk("R5 no log writes", 16'(we_seen - w0), 16'd0);
        rd_chk(3'd2, 16'h0000, "R5 status untouched");
        // program masks and list window
        wr_reg(3'd0, 16'h001F);
        wr_reg(3'd1, 16'h0300);
        wr_reg(3'd4, 16'd9);
        wr_reg(3'd3, 16'h0100);
        rd_chk(3'd5, 16'h0100, "R9 tail follows base");
        // single standard event
        fire(10'h001, 16'hA001, 16'hB001);
        idle(6);
        // three simultaneous standard events -> three pulses
        fire(10'h007, 16'hA002, 16'hB002);
        idle(6);
        // clear level while a new event arrives: event wins
        step(10'h010, 16'hA003, 16'hB003, 1, 3'd2, 16'h8000);
        idle(5);
        rd_chk(3'd2, 16'h8000, "R2 set beats clear");
        wr_reg(3'd2, 16'h8000);
        rd_chk(3'd2, 16'h0000, "R2 cleared");
        // high-priority events, mixed with a disabled one
        fire(10'h260, 16'hA004, 16'hB004);
        idle(6);
        rd_chk(3'd2, 16'h0200, "R4 hp bit 9 set");
        step(10'h100, 16'hA005, 16'hB005, 1, 3'd2, 16'h0300);
        idle(5);
        rd_chk(3'd2, 16'h0100, "R4 set beats clear");
        wr_reg(3'd2, 16'h0100);
        rd_chk(3'd2, 16'h0000, "R4 write one clears");
        // burst of four records: one dropped
        idle(2);
        w0 = we_seen;
        fire(10'h002, 16'hC001, 16'hD001);
        fire(10'h004, 16'hC002, 16'hD002);
        fire(10'h008, 16'hC003, 16'hD003);
        fire(10'h010, 16'hC004, 16'hD004);
        idle(16);
        chk("R10 records written", 16'(we_seen - w0), 16'd9);
        // move base mid-list, then log across wrap
        wr_reg(3'd3, 16'h0200);
        wr_reg(3'd4, 16'd6);
        for (int k = 0; k < 4; k++) begin
            fire(10'h001 << k, 16'hE000 + 16'(k), 16'hF000 + 16'(k));
            idle(5);
        end
        rd_chk(3'd5, 16'h0200, "R8 tail after wrap");
        idle(3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule